// File: doc/BRIEF.md
# Bidirectional GPIO Port with Direction Control

The block is an 8-bit general-purpose I/O port on a simple synchronous register bus. It holds an output data latch and a direction register, each at its own address. Each pin whose direction bit is set is driven from its latch bit. Each pin whose direction bit is clear has its driver off, so the pad is in high impedance. The pad drivers themselves sit outside the block and are controlled by the output-enable and output-value buses.

The pin inputs pass through a two-flop synchronizer. A read of the data address returns a per-bit blend. For output pins it gives the latch bit, and for input pins it gives the synchronized pin level. Software can always write the latch, whatever the direction of a pin. Loading the latch first and then turning the pin to output makes the pin drive the intended level from its first driven cycle.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it is released, every direction bit is 0 and the latch is 0x00. So `pin_oe` = 0x00 and `pin_out` = 0x00.
- R2: A write (`bus_wr`=1) to offset 0x00 loads `bus_wdata` into the latch on that clock edge, whatever the direction bits are. From the next cycle, `pin_out` equals the new latch value.
- R3: A write to offset 0x04 loads `bus_wdata` into the direction register on that clock edge. From the next cycle, `pin_oe` equals it, with bit i = 1 meaning pin i is driven. Without such a write, `pin_oe` does not change.
- R4: A read of offset 0x04 returns the direction register.
- R5: A read of offset 0x00 returns bit i of the latch where direction bit i is 1. Where direction bit i is 0, it returns bit i of the synchronized pin input.
- R6: A latch write to a bit whose direction is 0 does not change the value read back for that bit at offset 0x00.
- R7: If the latch is loaded before a direction bit goes from 0 to 1, then `pin_out` already holds the loaded value in the first cycle that `pin_oe` is 1.
- R8: A pin input level held from clock edge k onward is first returned by a data read sampled at edge k+2. Reads sampled at edges k and k+1 return the previous level.
- R9: Read data appears on `bus_rdata` in the cycle after the edge that samples `bus_rd`=1. It holds its value while no read is made. A read and a write in the same cycle return the value from before the write.
- R10: A read of any offset other than 0x00 or 0x04 returns 0x00. A write to such an offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_out | output | 8 | Per-pin output value to the pad |
| pin_oe | output | 8 | Per-pin output enable (1 = drive) |
| pin_in | input | 8 | Per-pin sampled pad level |

## Verification
On every cycle the assertions check four things. Writes to each register reach `pin_out` or `pin_oe` one cycle later. The enables change only after a direction write. Reads of unmapped offsets return zero. The read data register holds when no read is made. Only the bench scenarios can show the per-bit blend of latch and pin values, the two-edge latency of the synchronizer, the preload-then-enable sequence, and the fact that a latch write to an input bit leaves its read value unchanged, because these depend on the order of stimulus across many cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_W   = 8;
  localparam int unsigned GPIO_AW  = 8;
  localparam logic [GPIO_AW-1:0] OFS_DATA = 8'h00;
  localparam logic [GPIO_AW-1:0] OFS_DIR  = 8'h04;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [GPIO_AW-1:0] a);
    if (a == OFS_DATA)     return SEL_DATA;
    else if (a == OFS_DIR) return SEL_DIR;
    else                   return SEL_NONE;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_in[i];
        sync_q <= meta_q;
      end
    end
    assign d_sync[i] = sync_q;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  logic         latch_en;
  logic         dir_en;
  logic [W-1:0] latch_d;
  logic [W-1:0] dir_d;

  always_comb begin
    latch_en = wr_en && (wr_sel == SEL_DATA);
    dir_en   = wr_en && (wr_sel == SEL_DIR);
    latch_d  = latch_en ? wr_data : latch_q;
    dir_d    = dir_en   ? wr_data : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  // R2
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DATA) |=> (latch_q == $past(wr_data)));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_en,
  input  reg_sel_e     rd_sel,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata_q
);
  logic [W-1:0] rdata_d;
  logic [W-1:0] blend;

  always_comb begin
    blend = (latch_q & dir_q) | (pin_sync & ~dir_q);
    unique case (rd_sel)
      SEL_DATA: rdata_d = blend;
      SEL_DIR:  rdata_d = dir_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SEL_NONE) |=> (rdata_q == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W  = GPIO_W,
  parameter int unsigned AW = GPIO_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  input  logic [W-1:0]  pin_in
);
  reg_sel_e     sel;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pin_sync;

  assign sel = decode(bus_addr);

  gpio_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (pin_in),
    .d_sync (pin_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .wr_sel  (sel),
    .wr_data (bus_wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  gpio_rdmux #(.W(W)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd),
    .rd_sel   (sel),
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .rdata_q  (bus_rdata)
  );

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;

  // R3
  oe_follows_dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata)));

  // R2
  out_follows_data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA) |=> (pin_out == $past(bus_wdata)));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:0] pin_in;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic [7:0]  m_lat;
  logic [7:0]  m_dir;
  logic [7:0]  rv;

  always #10 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
  );

  function automatic logic [7:0] exp_data(input logic [7:0] l, input logic [7:0] d,
                                          input logic [7:0] p);
    return (l & d) | (p & ~d);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h00) m_lat = d;
    else if (a == 8'h04) m_dir = d;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic set_pins(input logic [7:0] p);
    pin_in = p;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; pin_in = 8'hA5;
    m_lat = '0; m_dir = '0;
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pin_oe, 8'h00);
    check("R1 out in reset", pin_out, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 oe after reset", pin_oe, 8'h00);
    check("R1 out after reset", pin_out, 8'h00);
    rd(8'h04, rv); check("R1 dir reads zero", rv, 8'h00);
    rd(8'h00, rv); check("R5 all-input read", rv, 8'hA5);

    // R2: latch written while all pins are inputs; R6: read unchanged
    wr(8'h00, 8'h3C);
    check("R2 pin_out after write", pin_out, 8'h3C);
    rd(8'h00, rv); check("R6 input read ignores latch", rv, 8'hA5);

    // R7: preload then enable
    wr(8'h00, 8'hF0);
    bus_addr = 8'h04; bus_wdata = 8'hFF; bus_wr = 1'b1;
    @(posedge clk); #1;
    check("R7 out valid at first oe", pin_out, 8'hF0);
    check("R3 oe at first cycle", pin_oe, 8'hFF);
    @(negedge clk); bus_wr = 1'b0; m_dir = 8'hFF;
    rd(8'h00, rv); check("R5 all-output read", rv, 8'hF0);

    // R10 unmapped
    wr(8'h01, 8'h55); wr(8'h08, 8'h55); wr(8'hFF, 8'h55);
    m_lat = 8'hF0; m_dir = 8'hFF;
    rd(8'h01, rv); check("R10 read 0x01", rv, 8'h00);
    rd(8'hFF, rv); check("R10 read 0xFF", rv, 8'h00);
    rd(8'h04, rv); check("R10 dir untouched", rv, 8'hFF);
    rd(8'h00, rv); check("R10 latch untouched", rv, 8'hF0);

    // R9 hold and read/write same cycle
    repeat (2) @(negedge clk);
    check("R9 rdata holds", bus_rdata, 8'hF0);
    bus_addr = 8'h04; bus_wdata = 8'h0F; bus_wr = 1'b1; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; m_dir = 8'h0F;
    check("R9 read before write", bus_rdata, 8'hFF);
    check("R3 oe after write", pin_oe, 8'h0F);

    // R8 synchronizer latency (low nibble drives latch 0, high nibble inputs)
    pin_in = 8'h00; repeat (3) @(negedge clk);
    pin_in = 8'hF0;
    rd(8'h00, rv); check("R8 edge k old", rv, 8'h00);
    rd(8'h00, rv); check("R8 edge k+1 old", rv, 8'h00);
    rd(8'h00, rv); check("R8 edge k+2 new", rv, 8'hF0);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned op = $urandom_range(0, 4);
      logic [7:0] d = 8'($urandom);
      case (op)
        0: wr(8'h00, d);
        1: wr(8'h04, d);
        2: set_pins(d);
        3: begin
          rd(8'h00, rv);
          check("R5 random data read", rv, exp_data(m_lat, m_dir, pin_in));
        end
        default: begin
          rd(8'h04, rv);
          check("R4 random dir read", rv, m_dir);
          check("R3 random oe", pin_oe, m_dir);
          check("R2 random out", pin_out, m_lat);
        end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule